// File: doc/BRIEF.md
# Four-Channel DMA Controller

The block is a DMA engine with four channels that copies data one unit at a time over a simple single-master bus. It handles memory to memory, memory to peripheral and peripheral to memory moves. Each channel holds two descriptors, primary and alternate. A descriptor gives a source address, a destination address, a unit count, a unit size, and a separate increment-or-fixed choice for each address. A fixed address suits a peripheral data register.

Software controls the block through paired registers. Writing a one to a set register turns a bit on, and writing a one to the matching clear register turns it off. These pairs cover channel enable, request mask, priority level and descriptor selection. A channel starts moving data when its peripheral request line is high or when software has posted a request for it. A single arbiter chooses the next channel before every unit. Completion and bus errors raise flags, and each flag can raise an interrupt when its enable is set. The engine needs no processor activity once a channel is armed, so it keeps working while the processor is halted.

Top module: `dma_mc`

## Requirements
- R1: After reset every control bit, flag, interrupt enable and descriptor field reads 0. The engine is idle, `bus_req_o` is low and both interrupt outputs are low.
- R2: Word offsets for the control pairs (set/clear) are: enable 2/3, mask 4/5, priority 6/7 and alternate select 8/9. Offsets 11/12 hold the interrupt enables: bits 3:0 are the completion enables and bit 4 is the error enable. Writing a one to a set offset sets that bit. Writing a one to a clear offset clears it. Zero bits have no effect. Either offset of a pair reads back the current bits in bit c for channel c.
- R3: Bit 0 of offset 0 is the master enable. While it is 0 the engine starts no transfer and makes no bus request. Its value reads back in bit 0 of the status word at offset 1.
- R4: A channel is eligible when it is enabled, not masked, and either its `hw_req_i` bit is high or a software request is pending. Writing a one to bit c of offset 10 posts a software request for channel c. The request stays pending until that channel completes or takes an error. A masked channel starts no unit, even with its request line held high.
- R5: Among eligible channels, a channel with its priority bit set wins over one without it. Between channels of equal priority, the lowest channel number wins. Arbitration runs again after each unit, so a newly eligible channel with a lower number takes over between two units.
- R6: One unit is a bus read at the source address followed by a bus write at the destination address. `bus_size_o` carries the size code: 0 for a byte, 1 for a halfword, 2 for a word. Data travels in the low bits of the data bus.
- R7: Descriptors are at offset 16 + 8·channel + 4·alt + field. Field 0 is the source address and field 1 is the destination address. Field 2 is the control word: bits 15:0 count, bits 17:16 size, bit 18 source increment, bit 19 destination increment. After each unit, each address moves on by 1, 2 or 4 bytes if its increment bit is set, or stays put if not. The count drops by one. The new values read back.
- R8: When the count reaches 0, the channel's enable bit clears and its completion flag sets. A channel granted while its count is already 0 completes without any bus access.
- R9: A channel uses its alternate descriptor when its alternate select bit is 1 and its primary descriptor when the bit is 0. The descriptor not in use is left untouched.
- R10: Offset 13 reads the flags: bits 3:0 are the per-channel completion flags and bit 4 is the error flag. Writing a one to a flag bit clears it. `done_irq_o` is the OR over channels of each completion flag ANDed with its enable. `err_irq_o` is the error flag ANDed with its enable.
- R11: A bus error on either the read or the write of a unit does four things. It sets the error flag. It clears the active channel's enable and pending software request. It leaves that channel's descriptor unchanged. It returns the engine to idle without issuing the write.
- R12: In the status word, bits 7:4 give the engine state: 0 idle, 1 reading, 2 writing, 3 done, 4 error. Bits 9:8 give the channel being serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | RAW (6) | Register word offset, used for both read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the register at `reg_addr_i` |
| hw_req_i | input | NCH (4) | Peripheral request lines, one per channel, level sensitive |
| bus_req_o | output | 1 | Bus access request, held until acknowledged or errored |
| bus_we_o | output | 1 | 1 for a write access, 0 for a read access |
| bus_addr_o | output | 32 | Byte address |
| bus_size_o | output | 2 | Access size code |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid together with the acknowledge |
| bus_ack_i | input | 1 | Access completed |
| bus_err_i | input | 1 | Access failed |
| done_irq_o | output | 1 | Completion interrupt |
| err_irq_o | output | 1 | Error interrupt |

## Verification
A register write takes effect at the clock edge that ends the write cycle, and read data follows the offset combinationally. The bench therefore samples every result at the falling edge after the write. With a zero-wait bus a unit takes three cycles: the idle cycle that grants a channel, then one cycle each for the read and the write. Completion adds one more cycle before the flag shows. The bench does not predict those cycles exactly. It polls the flags with a bounded wait, then checks memory contents, read-back descriptors and the logged order of read addresses. To catch the engine in its reading state, the bench holds off the bus acknowledge, so the status and address checks are made while the access is frozen.

// File: rtl/dma_mc_pkg.sv
package dma_mc_pkg;
  localparam int AW = 32;
  localparam int CW = 16;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_READ  = 4'd1,
    ST_WRITE = 4'd2,
    ST_DONE  = 4'd3,
    ST_ERR   = 4'd4
  } eng_state_e;

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [CW-1:0] cnt;
    logic [1:0]    size;
    logic          src_inc;
    logic          dst_inc;
  } desc_t;

  function automatic logic [AW-1:0] unit_bytes(input logic [1:0] size);
    case (size)
      2'd0:    return AW'(1);
      2'd1:    return AW'(2);
      default: return AW'(4);
    endcase
  endfunction
endpackage

// File: rtl/dma_mc_regs.sv
module dma_mc_regs
  import dma_mc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CHW = 2,
  parameter int RAW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RAW-1:0]  addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  eng_state_e      state_i,
  input  logic [CHW-1:0]  cur_ch_i,
  input  logic            upd_i,
  input  desc_t           upd_desc_i,
  input  logic            fin_i,
  input  logic            err_i,
  output logic            master_en_o,
  output logic [NCH-1:0]  en_o,
  output logic [NCH-1:0]  mask_o,
  output logic [NCH-1:0]  pri_o,
  output logic [NCH-1:0]  swp_o,
  output desc_t           desc_o [NCH],
  output logic            done_irq_o,
  output logic            err_irq_o
);
  localparam logic [RAW-1:0] A_CFG = RAW'(0),  A_STAT = RAW'(1);
  localparam logic [RAW-1:0] A_ENS = RAW'(2),  A_ENC  = RAW'(3);
  localparam logic [RAW-1:0] A_MSS = RAW'(4),  A_MSC  = RAW'(5);
  localparam logic [RAW-1:0] A_PRS = RAW'(6),  A_PRC  = RAW'(7);
  localparam logic [RAW-1:0] A_ALS = RAW'(8),  A_ALC  = RAW'(9);
  localparam logic [RAW-1:0] A_SWR = RAW'(10), A_IES  = RAW'(11);
  localparam logic [RAW-1:0] A_IEC = RAW'(12), A_FLG  = RAW'(13);
  localparam logic [RAW-1:0] DBASE = RAW'(16);

  logic            master_q;
  logic [NCH-1:0]  en_q, msk_q, pri_q, alt_q, swp_q;
  logic [NCH:0]    ie_q, flg_q;
  desc_t           desc_q [NCH][2];

  logic [NCH-1:0]  wm, hw_clr;
  logic [NCH:0]    wf;
  logic [RAW-1:0]  doff;
  logic [RAW-4:0]  dch;
  logic            dhit;

  assign wm     = wdata_i[NCH-1:0];
  assign wf     = wdata_i[NCH:0];
  assign hw_clr = (fin_i || err_i) ? (NCH'(1) << cur_ch_i) : '0;
  assign doff   = addr_i - DBASE;
  assign dch    = doff[RAW-1:3];
  assign dhit   = (addr_i >= DBASE) && (int'(dch) < NCH);

  function automatic logic [NCH-1:0] wr_bits(input logic [RAW-1:0] a, input logic we,
                                             input logic [RAW-1:0] adr, input logic [NCH-1:0] d);
    return (we && adr == a) ? d : '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      en_q <= '0; msk_q <= '0; pri_q <= '0; alt_q <= '0; swp_q <= '0;
      ie_q <= '0; flg_q <= '0;
      for (int c = 0; c < NCH; c++)
        for (int a = 0; a < 2; a++) desc_q[c][a] <= '0;
    end else begin
      if (we_i && addr_i == A_CFG) master_q <= wdata_i[0];
      // hardware clear wins over a software set in the same cycle
      en_q  <= (en_q | wr_bits(A_ENS, we_i, addr_i, wm)) & ~wr_bits(A_ENC, we_i, addr_i, wm) & ~hw_clr;
      msk_q <= (msk_q | wr_bits(A_MSS, we_i, addr_i, wm)) & ~wr_bits(A_MSC, we_i, addr_i, wm);
      pri_q <= (pri_q | wr_bits(A_PRS, we_i, addr_i, wm)) & ~wr_bits(A_PRC, we_i, addr_i, wm);
      alt_q <= (alt_q | wr_bits(A_ALS, we_i, addr_i, wm)) & ~wr_bits(A_ALC, we_i, addr_i, wm);
      swp_q <= (swp_q | wr_bits(A_SWR, we_i, addr_i, wm)) & ~hw_clr;
      if (we_i && addr_i == A_IES) ie_q <= ie_q | wf;
      else if (we_i && addr_i == A_IEC) ie_q <= ie_q & ~wf;
      flg_q <= (flg_q & ~((we_i && addr_i == A_FLG) ? wf : '0))
             | {err_i, (fin_i ? hw_clr : NCH'(0))};
      for (int c = 0; c < NCH; c++) begin
        if (we_i && dhit && int'(dch) == c) begin
          case (doff[1:0])
            2'd0: desc_q[c][doff[2]].src <= wdata_i;
            2'd1: desc_q[c][doff[2]].dst <= wdata_i;
            2'd2: desc_q[c][doff[2]] <= {desc_q[c][doff[2]].src, desc_q[c][doff[2]].dst,
                                         wdata_i[CW-1:0], wdata_i[CW+1:CW], wdata_i[CW+2], wdata_i[CW+3]};
            default: ;
          endcase
        end
        if (upd_i && int'(cur_ch_i) == c) begin
          desc_q[c][alt_q[c]].src <= upd_desc_i.src;
          desc_q[c][alt_q[c]].dst <= upd_desc_i.dst;
          desc_q[c][alt_q[c]].cnt <= upd_desc_i.cnt;
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) desc_o[c] = desc_q[c][alt_q[c]];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CFG:         rdata_o[0] = master_q;
      A_STAT: begin
        rdata_o[0]         = master_q;
        rdata_o[7:4]       = state_i;
        rdata_o[8 +: CHW]  = cur_ch_i;
      end
      A_ENS, A_ENC:  rdata_o[NCH-1:0] = en_q;
      A_MSS, A_MSC:  rdata_o[NCH-1:0] = msk_q;
      A_PRS, A_PRC:  rdata_o[NCH-1:0] = pri_q;
      A_ALS, A_ALC:  rdata_o[NCH-1:0] = alt_q;
      A_SWR:         rdata_o[NCH-1:0] = swp_q;
      A_IES, A_IEC:  rdata_o[NCH:0]   = ie_q;
      A_FLG:         rdata_o[NCH:0]   = flg_q;
      default: if (dhit) begin
        case (doff[1:0])
          2'd0:    rdata_o = desc_q[dch[CHW-1:0]][doff[2]].src;
          2'd1:    rdata_o = desc_q[dch[CHW-1:0]][doff[2]].dst;
          2'd2:    rdata_o = 32'({desc_q[dch[CHW-1:0]][doff[2]].dst_inc, desc_q[dch[CHW-1:0]][doff[2]].src_inc,
                                  desc_q[dch[CHW-1:0]][doff[2]].size, desc_q[dch[CHW-1:0]][doff[2]].cnt});
          default: rdata_o = '0;
        endcase
      end
    endcase
  end

  assign master_en_o = master_q;
  assign en_o        = en_q;
  assign mask_o      = msk_q;
  assign pri_o       = pri_q;
  assign swp_o       = swp_q;
  assign done_irq_o  = |(flg_q[NCH-1:0] & ie_q[NCH-1:0]);
  assign err_irq_o   = flg_q[NCH] & ie_q[NCH];

  // R8
  fin_clears_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> ((en_q & $past(hw_clr)) == '0));
  // R11
  err_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> (flg_q[NCH] && (swp_q & $past(hw_clr)) == '0));
  // R10
  flag_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_FLG && wdata_i[NCH] && !err_i) |=> !flg_q[NCH]);
endmodule

// File: rtl/dma_mc_arb.sv
module dma_mc_arb #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] elig_i,
  input  logic [NCH-1:0] pri_i,
  output logic           valid_o,
  output logic [CHW-1:0] idx_o
);
  logic [NCH-1:0] hi, cand;

  always_comb begin
    hi      = elig_i & pri_i;
    cand    = (|hi) ? hi : elig_i;
    valid_o = |cand;
    idx_o   = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (cand[i]) idx_o = CHW'(i);
  end

  always_comb begin
    // R4
    arb_elig_chk: assert (!valid_o || elig_i[idx_o]);
    // R5
    arb_pri_chk: assert (!(valid_o && (|(elig_i & pri_i))) || pri_i[idx_o]);
  end
endmodule

// File: rtl/dma_mc_eng.sv
module dma_mc_eng
  import dma_mc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           master_en_i,
  input  logic           valid_i,
  input  logic [CHW-1:0] idx_i,
  input  desc_t          desc_i [NCH],
  output logic           bus_req_o,
  output logic           bus_we_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [1:0]     bus_size_o,
  output logic [31:0]    bus_wdata_o,
  input  logic [31:0]    bus_rdata_i,
  input  logic           bus_ack_i,
  input  logic           bus_err_i,
  output eng_state_e     state_o,
  output logic [CHW-1:0] ch_o,
  output logic           upd_o,
  output desc_t          upd_desc_o,
  output logic           fin_o,
  output logic           err_o
);
  eng_state_e     st_q;
  logic [CHW-1:0] ch_q;
  logic [31:0]    dat_q, rd_masked;
  desc_t          cur;

  assign cur = desc_i[ch_q];

  always_comb begin
    case (cur.size)
      2'd0:    rd_masked = {24'd0, bus_rdata_i[7:0]};
      2'd1:    rd_masked = {16'd0, bus_rdata_i[15:0]};
      default: rd_masked = bus_rdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ch_q  <= '0;
      dat_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (master_en_i && valid_i) begin
          ch_q <= idx_i;
          st_q <= (desc_i[idx_i].cnt == '0) ? ST_DONE : ST_READ;
        end
        ST_READ: if (bus_err_i) st_q <= ST_ERR;
                 else if (bus_ack_i) begin
                   dat_q <= rd_masked;
                   st_q  <= ST_WRITE;
                 end
        ST_WRITE: if (bus_err_i) st_q <= ST_ERR;
                  else if (bus_ack_i) st_q <= (cur.cnt == CW'(1)) ? ST_DONE : ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_o   = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign bus_we_o    = (st_q == ST_WRITE);
  assign bus_addr_o  = (st_q == ST_WRITE) ? cur.dst : cur.src;
  assign bus_size_o  = cur.size;
  assign bus_wdata_o = dat_q;
  assign upd_o       = (st_q == ST_WRITE) && bus_ack_i && !bus_err_i;
  always_comb begin
    upd_desc_o     = cur;
    upd_desc_o.src = cur.src + (cur.src_inc ? unit_bytes(cur.size) : '0);
    upd_desc_o.dst = cur.dst + (cur.dst_inc ? unit_bytes(cur.size) : '0);
    upd_desc_o.cnt = cur.cnt - CW'(1);
  end
  assign fin_o   = (st_q == ST_DONE);
  assign err_o   = (st_q == ST_ERR);
  assign state_o = st_q;
  assign ch_o    = ch_q;

  // R3
  master_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !master_en_i) |=> (st_q == ST_IDLE));
  // R11
  bus_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_err_i) |=> (st_q == ST_ERR && !bus_req_o));
  // R6
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && !bus_err_i) |=> (bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o)));
  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (cur.cnt != '0));
  // R12
  ch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(ch_q));
endmodule

// File: rtl/dma_mc.sv
module dma_mc
  import dma_mc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int RAW = $clog2(16 + 8 * NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RAW-1:0]  reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic [NCH-1:0]  hw_req_i,
  output logic            bus_req_o,
  output logic            bus_we_o,
  output logic [31:0]     bus_addr_o,
  output logic [1:0]      bus_size_o,
  output logic [31:0]     bus_wdata_o,
  input  logic [31:0]     bus_rdata_i,
  input  logic            bus_ack_i,
  input  logic            bus_err_i,
  output logic            done_irq_o,
  output logic            err_irq_o
);
  eng_state_e     state;
  logic [CHW-1:0] cur_ch, win_idx;
  logic           upd, fin, err, master_en, win_valid;
  desc_t          upd_desc;
  desc_t          desc [NCH];
  logic [NCH-1:0] en, mask, pri, swp, elig;

  assign elig = en & ~mask & (hw_req_i | swp);

  dma_mc_regs #(.NCH(NCH), .CHW(CHW), .RAW(RAW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .state_i(state), .cur_ch_i(cur_ch), .upd_i(upd), .upd_desc_i(upd_desc),
    .fin_i(fin), .err_i(err), .master_en_o(master_en),
    .en_o(en), .mask_o(mask), .pri_o(pri), .swp_o(swp), .desc_o(desc),
    .done_irq_o, .err_irq_o
  );

  dma_mc_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .elig_i(elig), .pri_i(pri), .valid_o(win_valid), .idx_o(win_idx)
  );

  dma_mc_eng #(.NCH(NCH), .CHW(CHW)) u_eng (
    .clk_i, .rst_ni,
    .master_en_i(master_en), .valid_i(win_valid), .idx_i(win_idx), .desc_i(desc),
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_size_o, .bus_wdata_o,
    .bus_rdata_i, .bus_ack_i, .bus_err_i,
    .state_o(state), .ch_o(cur_ch), .upd_o(upd), .upd_desc_o(upd_desc),
    .fin_o(fin), .err_o(err)
  );
endmodule

// File: tb/tb_dma_mc.sv
module tb_dma_mc;
  localparam int A_CFG = 0, A_STAT = 1, A_ENS = 2, A_ENC = 3, A_MSS = 4, A_MSC = 5;
  localparam int A_PRS = 6, A_PRC = 7, A_ALS = 8, A_ALC = 9, A_SWR = 10;
  localparam int A_IES = 11, A_IEC = 12, A_FLG = 13;
  localparam int NV = 4;
  localparam int V_CH  [NV] = '{0, 1, 2, 3};
  localparam int V_SZ  [NV] = '{0, 1, 2, 2};
  localparam int V_SI  [NV] = '{1, 1, 1, 0};
  localparam int V_DI  [NV] = '{1, 1, 0, 1};
  localparam int V_SRC [NV] = '{'h010, 'h020, 'h040, 'h060};
  localparam int V_DST [NV] = '{'h200, 'h240, 'h280, 'h2C0};
  localparam int V_CNT [NV] = '{5, 3, 4, 3};

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [3:0]  hw_req = 0;
  logic        bus_req, bus_we, bus_ack, bus_err, done_irq, err_irq;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        stall = 0;
  logic        finished = 0;
  int          ncmp = 0, nerr = 0, nbus = 0, nwr = 0, ridx = 0;
  logic [31:0] rlog [16];
  logic [7:0]  mem [1024];
  logic [9:0]  ba;

  always #4 clk = ~clk;

  dma_mc dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .hw_req_i(hw_req),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_size_o(bus_size),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack), .bus_err_i(bus_err),
    .done_irq_o(done_irq), .err_irq_o(err_irq)
  );

  function automatic logic [7:0] initv(input int a);
    return 8'(a * 7 + 3);
  endfunction

  assign ba        = bus_addr[9:0];
  assign bus_ack   = bus_req && !stall && (bus_addr < 32'h400);
  assign bus_err   = bus_req && !stall && (bus_addr >= 32'h400);
  assign bus_rdata = {mem[ba + 10'd3], mem[ba + 10'd2], mem[ba + 10'd1], mem[ba]};

  always @(posedge clk) begin
    if (bus_req && bus_ack) begin
      nbus++;
      if (bus_we) begin
        nwr++;
        for (int b = 0; b < 4; b++)
          if (b < (bus_size == 0 ? 1 : bus_size == 1 ? 2 : 4)) mem[ba + 10'(b)] = bus_wdata[8*b +: 8];
      end else if (ridx < 16) begin
        rlog[ridx] = bus_addr;
        ridx++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 6'(a);
    #1 v = reg_rdata;
  endtask

  task automatic set_desc(input int ch, input int alt, input int src, input int dst,
                          input int cnt, input int sz, input int si, input int di);
    wr(16 + ch * 8 + alt * 4 + 0, 32'(src));
    wr(16 + ch * 8 + alt * 4 + 1, 32'(dst));
    wr(16 + ch * 8 + alt * 4 + 2, 32'(cnt) | (32'(sz) << 16) | (32'(si) << 18) | (32'(di) << 19));
  endtask

  task automatic wait_flags(input logic [31:0] m);
    logic [31:0] v;
    for (int n = 0; n < 400; n++) begin
      rd(A_FLG, v);
      if ((v & m) == m) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base_bus, base_wr, bad, sz, len;
    logic [7:0] e [64];
    for (int i = 0; i < 1024; i++) mem[i] = initv(i);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_FLG, v);  chk("R1 flags", v, 0);
    rd(A_ENS, v);  chk("R1 enable", v, 0);
    rd(16 + 2, v); chk("R1 desc ctrl", v, 0);
    chk("R1 bus_req/irq", {29'd0, bus_req, done_irq, err_irq}, 0);

    // R2 set/clear pairs, master still off
    wr(A_ENS, 32'hA); rd(A_ENC, v); chk("R2 en set", v, 32'hA);
    wr(A_ENS, 32'h1); rd(A_ENS, v); chk("R2 en set keeps others", v, 32'hB);
    wr(A_ENC, 32'h2); rd(A_ENS, v); chk("R2 en clear", v, 32'h9);
    wr(A_ENC, 32'hF);
    wr(A_PRS, 32'h6); wr(A_PRC, 32'h2); rd(A_PRS, v); chk("R2 pri pair", v, 32'h4);
    wr(A_PRC, 32'hF);
    wr(A_IES, 32'h11); wr(A_IEC, 32'h01); rd(A_IEC, v); chk("R2 ie pair", v, 32'h10);
    wr(A_IEC, 32'h1F);

    // R3 master enable gates activity
    set_desc(0, 0, 'h010, 'h3D0, 1, 0, 1, 1);
    base_bus = nbus;
    wr(A_ENS, 1); wr(A_SWR, 1);
    repeat (20) @(negedge clk);
    chk("R3 no bus while master off", 32'(nbus - base_bus), 0);
    rd(A_STAT, v); chk("R3 status master bit", v & 32'hF1, 0);
    wr(A_CFG, 1);
    rd(A_STAT, v); chk("R3 status master on", v & 32'h1, 1);
    wait_flags(1);
    chk("R3 transfer after enable", 32'(mem['h3D0]), 32'(initv('h010)));
    wr(A_FLG, 1);

    // R6 R7 R8 vector table
    for (int k = 0; k < NV; k++) begin
      sz = (V_SZ[k] == 0) ? 1 : (V_SZ[k] == 1) ? 2 : 4;
      len = V_DI[k] ? V_CNT[k] * sz : sz;
      for (int j = 0; j < 64; j++) e[j] = initv(V_DST[k] + j);
      for (int u = 0; u < V_CNT[k]; u++)
        for (int b = 0; b < sz; b++)
          e[(V_DI[k] ? u * sz : 0) + b] = initv(V_SRC[k] + (V_SI[k] ? u * sz : 0) + b);
      set_desc(V_CH[k], 0, V_SRC[k], V_DST[k], V_CNT[k], V_SZ[k], V_SI[k], V_DI[k]);
      wr(A_ENS, 32'(1) << V_CH[k]); wr(A_SWR, 32'(1) << V_CH[k]);
      wait_flags(32'(1) << V_CH[k]);
      bad = 0;
      for (int j = 0; j < len + 4; j++) if (mem[V_DST[k] + j] !== e[j]) bad++;
      chk($sformatf("R6 vector %0d dest bytes mismatched", k), 32'(bad), 0);
      rd(A_FLG, v); chk($sformatf("R8 vector %0d done flag", k), v & (32'(1) << V_CH[k]), 32'(1) << V_CH[k]);
      rd(A_ENS, v); chk($sformatf("R8 vector %0d enable cleared", k), v & (32'(1) << V_CH[k]), 0);
      rd(16 + V_CH[k] * 8 + 2, v); chk($sformatf("R7 vector %0d count", k), v & 32'hFFFF, 0);
      rd(16 + V_CH[k] * 8 + 0, v);
      chk($sformatf("R7 vector %0d src step", k), v, 32'(V_SRC[k] + (V_SI[k] ? V_CNT[k] * sz : 0)));
      rd(16 + V_CH[k] * 8 + 1, v);
      chk($sformatf("R7 vector %0d dst step", k), v, 32'(V_DST[k] + (V_DI[k] ? V_CNT[k] * sz : 0)));
    end

    // R10 completion interrupt with flags from the vectors
    chk("R10 done_irq masked", 32'(done_irq), 0);
    wr(A_IES, 32'h1); #1 chk("R10 done_irq enabled", 32'(done_irq), 1);
    wr(A_FLG, 32'h1); #1 chk("R10 done_irq after w1c", 32'(done_irq), 0);
    rd(A_FLG, v); chk("R10 flag w1c only bit0", v, 32'hE);
    wr(A_IEC, 32'h1F); wr(A_FLG, 32'h1F);

    // R5 priority then lowest index
    set_desc(1, 0, 'h100, 'h380, 2, 0, 1, 1);
    set_desc(2, 0, 'h180, 'h390, 2, 0, 1, 1);
    set_desc(3, 0, 'h1C0, 'h3A0, 2, 0, 1, 1);
    wr(A_PRS, 32'h4);
    stall = 1; ridx = 0;
    wr(A_ENS, 32'hE); hw_req = 4'hE;
    repeat (3) @(negedge clk);
    stall = 0;
    wait_flags(32'hE);
    hw_req = 0;
    chk("R5 high priority first", rlog[0], 32'h180);
    chk("R5 high priority keeps", rlog[1], 32'h181);
    chk("R5 tie lowest index", rlog[2], 32'h100);
    chk("R5 last channel", rlog[4], 32'h1C0);
    wr(A_PRC, 32'hF); wr(A_FLG, 32'h1F);

    // R5 R12 re-arbitration between units, status while stalled
    set_desc(3, 0, 'h1C0, 'h3A0, 3, 0, 1, 1);
    set_desc(1, 0, 'h100, 'h380, 2, 0, 1, 1);
    stall = 1; ridx = 0;
    wr(A_ENS, 32'h8); hw_req = 4'h8;
    repeat (3) @(negedge clk);
    rd(A_STAT, v); chk("R12 status reading ch3", v & 32'h3F1, 32'h311);
    chk("R6 read address", bus_addr, 32'h1C0);
    chk("R6 read size", 32'(bus_size), 0);
    wr(A_ENS, 32'h2); hw_req = 4'hA;
    stall = 0;
    wait_flags(32'hA);
    hw_req = 0;
    chk("R5 unit finishes", rlog[0], 32'h1C0);
    chk("R5 lower index takes over", rlog[1], 32'h100);
    chk("R5 resumes", rlog[3], 32'h1C1);
    wr(A_FLG, 32'h1F);

    // R4 mask blocks a held request
    set_desc(0, 0, 'h010, 'h3C0, 2, 0, 1, 1);
    wr(A_MSS, 1);
    base_bus = nbus;
    wr(A_ENS, 1); hw_req = 4'h1;
    repeat (30) @(negedge clk);
    chk("R4 masked no bus", 32'(nbus - base_bus), 0);
    rd(A_ENS, v); chk("R4 masked still enabled", v & 1, 1);
    wr(A_MSC, 1);
    wait_flags(1);
    hw_req = 0;
    chk("R4 unmasked transfer", 32'(mem['h3C1]), 32'(initv('h011)));
    wr(A_FLG, 32'h1F);

    // R8 zero count
    set_desc(2, 0, 'h040, 'h280, 0, 2, 1, 1);
    base_bus = nbus;
    wr(A_ENS, 4); wr(A_SWR, 4);
    wait_flags(4);
    chk("R8 zero count no bus", 32'(nbus - base_bus), 0);
    rd(A_ENS, v); chk("R8 zero count disabled", v & 4, 0);
    wr(A_FLG, 32'h1F);

    // R9 alternate descriptor
    set_desc(1, 0, 'h020, 'h3F0, 5, 0, 1, 1);
    set_desc(1, 1, 'h300, 'h340, 2, 2, 1, 1);
    wr(A_ALS, 2); rd(A_ALC, v); chk("R9 alt readback", v, 2);
    wr(A_ENS, 2); wr(A_SWR, 2);
    wait_flags(2);
    bad = 0;
    for (int j = 0; j < 8; j++) if (mem['h340 + j] !== initv('h300 + j)) bad++;
    chk("R9 alt dest bytes mismatched", 32'(bad), 0);
    rd(16 + 8 + 2, v); chk("R9 primary untouched", v & 32'hFFFF, 5);
    rd(16 + 8 + 4 + 2, v); chk("R9 alt count zero", v & 32'hFFFF, 0);
    wr(A_ALC, 2); wr(A_FLG, 32'h1F);

    // R11 bus error
    set_desc(0, 0, 'h500, 'h3E0, 3, 0, 1, 1);
    wr(A_IES, 32'h10);
    base_wr = nwr;
    wr(A_ENS, 1); wr(A_SWR, 1);
    wait_flags(32'h10);
    chk("R11 err_irq", 32'(err_irq), 1);
    rd(A_ENS, v); chk("R11 enable cleared", v & 1, 0);
    rd(A_SWR, v); chk("R11 sw request cleared", v & 1, 0);
    chk("R11 no write", 32'(nwr - base_wr), 0);
    rd(16 + 2, v); chk("R11 count unchanged", v & 32'hFFFF, 3);
    rd(A_STAT, v); chk("R12 idle after error", v & 32'hF0, 0);
    rd(A_FLG, v); chk("R11 no done flag", v & 32'hF, 0);
    wr(A_FLG, 32'h10); #1 chk("R10 err_irq cleared", 32'(err_irq), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule